// File: doc/BRIEF.md
# Video controller register front end: scroll and address latch

This block holds the write-side register file that a CPU uses to program a tile-based video controller. Only the low three bits of the CPU offset choose the register, so the eight register slots repeat across any wider window the bus decoder hands the block. It keeps the control byte, the mask byte and the sprite-table address byte. It also keeps a 15-bit staging ("temporary") video address, a 3-bit fine horizontal scroll and the live video address that the memory port uses.

The scroll slot and the address slot each take two byte writes. A single phase bit, shared by both slots, chooses whether a write is the first or the second byte. Each write merges its bits into fixed fields of the staging address. The second address write copies the staging address into the live address. Reading the status slot returns the vertical-blank flag, clears that flag and returns the phase bit to "first byte". A last-written-byte latch supplies the data bits that no register drives. The block does not cover rendering, video memory and the data slot itself.

Top module: `vdc_reg_front`

## Requirements
- R1: While rst_ni is low, every register clears: control, mask, sprite address, staging address, fine scroll, live address, the phase bit, the vertical-blank flag and the last-byte latch. A read of any slot then returns 0x00.
- R2: Only offset_i[2:0] selects the slot. Slot codes are control=0, mask=1, status=2, sprite address=3, sprite data=4, scroll=5, address=6, data=7. Offsets 0x0D and 0x16 therefore act as scroll and address.
- R3: A write to slot 0 stores the byte in ctrl_o and copies data bits 1:0 into staging bits 11:10. All other staging bits are kept.
- R4: A write to slot 1 stores the byte in mask_o. A write to slot 3 stores the byte in oam_addr_o.
- R5: A scroll write with the phase bit at 0 puts data bits 2:0 into fine_x_o and data bits 7:3 into staging bits 4:0, then sets the phase bit. Fine scroll changes on no other write.
- R6: A scroll write with the phase bit at 1 puts data bits 2:0 into staging bits 14:12 and data bits 7:3 into staging bits 9:5, then clears the phase bit. Fine scroll is kept.
- R7: An address write with the phase bit at 0 puts data bits 5:0 into staging bits 13:8, clears staging bit 14, keeps staging bits 7:0 and sets the phase bit.
- R8: An address write with the phase bit at 1 replaces staging bits 7:0 and copies the new staging address into vaddr_o, then clears the phase bit. vaddr_o changes on no other event.
- R9: Scroll and address writes share one phase bit. A first scroll write followed by an address write makes that address write a second-byte write.
- R10: A status read (rd_en_i high, wr_en_i low, slot 2) returns {vblank, 2'b00, latch[4:0]}. At the next edge it clears the vertical-blank flag and the phase bit.
- R11: vblank_set_i sets the vertical-blank flag at the next edge. When it arrives together with a status read, the set wins and the flag stays 1.
- R12: Every write, including writes to slots 2, 4 and 7, loads the written byte into the last-byte latch. Writes to slots 2, 4 and 7 change no other register.
- R13: A read of any slot other than 2 returns the last-byte latch unchanged and leaves the phase bit and the vertical-blank flag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| rd_en_i | input | 1 | CPU read strobe, one cycle per read |
| offset_i | input | CPU_AW (8) | CPU offset; low 3 bits select the slot |
| wdata_i | input | 8 | Write data |
| vblank_set_i | input | 1 | Pulse from timing logic that sets the vertical-blank flag |
| rdata_o | output | 8 | Read data for the selected slot (combinational) |
| ctrl_o | output | 8 | Control register |
| mask_o | output | 8 | Mask register |
| oam_addr_o | output | 8 | Sprite-table address register |
| tmp_addr_o | output | 15 | Staging video address |
| fine_x_o | output | 3 | Fine horizontal scroll |
| vaddr_o | output | 15 | Live video address |
| write_phase_o | output | 1 | Shared two-write phase bit (1 = next write is the second byte) |

## Verification
The hardest state to reach is a phase bit that one slot leaves behind and the other slot then uses. In that state a scroll write is followed by an address write, or a status read lands between the two halves of a pair. The vector table strings writes together so that the phase bit carries from scroll into address and back, and it does so through aliased offsets. Directed steps then put a status read between two halves. They also send a vblank pulse in the same cycle as a status read, to show which of the two wins.

// File: rtl/vdc_reg_pkg.sv
package vdc_reg_pkg;
  localparam int unsigned VA_W = 15;
  localparam int unsigned FX_W = 3;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SLOT_CTRL   = 3'd0,
    SLOT_MASK   = 3'd1,
    SLOT_STAT   = 3'd2,
    SLOT_OAMA   = 3'd3,
    SLOT_OAMD   = 3'd4,
    SLOT_SCROLL = 3'd5,
    SLOT_ADDR   = 3'd6,
    SLOT_DATA   = 3'd7
  } slot_e;
endpackage

// File: rtl/vdc_addr_merge.sv
module vdc_addr_merge
  import vdc_reg_pkg::*;
(
  input  logic            wr_i,
  input  slot_e           sel_i,
  input  logic [7:0]      wdata_i,
  input  logic            phase_i,
  input  logic [VA_W-1:0] tmp_i,
  input  logic [FX_W-1:0] fx_i,
  output logic [VA_W-1:0] tmp_o,
  output logic [FX_W-1:0] fx_o,
  output logic            phase_o,
  output logic            vaddr_ld_o
);
  always_comb begin
    tmp_o      = tmp_i;
    fx_o       = fx_i;
    phase_o    = phase_i;
    vaddr_ld_o = 1'b0;
    if (wr_i) begin
      unique case (sel_i)
        SLOT_CTRL: tmp_o[11:10] = wdata_i[1:0];
        SLOT_SCROLL: begin
          if (!phase_i) begin
            fx_o       = wdata_i[2:0];
            tmp_o[4:0] = wdata_i[7:3];
          end else begin
            tmp_o[14:12] = wdata_i[2:0];
            tmp_o[9:5]   = wdata_i[7:3];
          end
          phase_o = ~phase_i;
        end
        SLOT_ADDR: begin
          if (!phase_i) begin
            tmp_o[13:8] = wdata_i[5:0];
            tmp_o[14]   = 1'b0;
          end else begin
            tmp_o[7:0] = wdata_i;
            vaddr_ld_o = 1'b1;
          end
          phase_o = ~phase_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vdc_status_port.sv
module vdc_status_port
  import vdc_reg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       vblank_set_i,
  input  logic       stat_rd_i,
  input  slot_e      sel_i,
  input  logic [7:0] open_bus_i,
  output logic [7:0] rdata_o,
  output logic       vblank_o
);
  logic vblank_q;

  // set beats a coincident read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           vblank_q <= 1'b0;
    else if (vblank_set_i) vblank_q <= 1'b1;
    else if (stat_rd_i)    vblank_q <= 1'b0;
  end

  always_comb begin
    if (sel_i == SLOT_STAT) rdata_o = {vblank_q, 2'b00, open_bus_i[4:0]};
    else                    rdata_o = open_bus_i;
  end

  assign vblank_o = vblank_q;
endmodule

// File: rtl/vdc_reg_front.sv
module vdc_reg_front
  import vdc_reg_pkg::*;
#(
  parameter int unsigned CPU_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [CPU_AW-1:0] offset_i,
  input  logic [7:0]        wdata_i,
  input  logic              vblank_set_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        oam_addr_o,
  output logic [VA_W-1:0]   tmp_addr_o,
  output logic [FX_W-1:0]   fine_x_o,
  output logic [VA_W-1:0]   vaddr_o,
  output logic              write_phase_o
);
  localparam int unsigned NBYTE = 3;
  localparam slot_e BYTE_SLOT [NBYTE] = '{SLOT_CTRL, SLOT_MASK, SLOT_OAMA};

  slot_e           sel;
  logic            stat_rd;
  logic [7:0]      open_bus_q;
  logic [7:0]      byte_q [NBYTE];
  logic [VA_W-1:0] tmp_q, tmp_d, vaddr_q;
  logic [FX_W-1:0] fx_q, fx_d;
  logic            phase_q, phase_d, vaddr_ld;
  logic            vblank;

  assign sel     = slot_e'(offset_i[SEL_W-1:0]);
  assign stat_rd = rd_en_i && !wr_en_i && (sel == SLOT_STAT);

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             byte_q[g] <= '0;
      else if (wr_en_i && sel == BYTE_SLOT[g]) byte_q[g] <= wdata_i;
    end
  end

  vdc_addr_merge u_merge (
    .wr_i       (wr_en_i),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .phase_i    (phase_q),
    .tmp_i      (tmp_q),
    .fx_i       (fx_q),
    .tmp_o      (tmp_d),
    .fx_o       (fx_d),
    .phase_o    (phase_d),
    .vaddr_ld_o (vaddr_ld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q      <= '0;
      fx_q       <= '0;
      vaddr_q    <= '0;
      phase_q    <= 1'b0;
      open_bus_q <= '0;
    end else begin
      tmp_q   <= tmp_d;
      fx_q    <= fx_d;
      phase_q <= stat_rd ? 1'b0 : phase_d;
      if (vaddr_ld) vaddr_q <= tmp_d;
      if (wr_en_i) open_bus_q <= wdata_i;
    end
  end

  vdc_status_port u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .vblank_set_i (vblank_set_i),
    .stat_rd_i    (stat_rd),
    .sel_i        (sel),
    .open_bus_i   (open_bus_q),
    .rdata_o      (rdata_o),
    .vblank_o     (vblank)
  );

  assign ctrl_o        = byte_q[0];
  assign mask_o        = byte_q[1];
  assign oam_addr_o    = byte_q[2];
  assign tmp_addr_o    = tmp_q;
  assign fine_x_o      = fx_q;
  assign vaddr_o       = vaddr_q;
  assign write_phase_o = phase_q;
endmodule

// File: rtl/vdc_reg_front_chk.sv
module vdc_reg_front_chk #(
  parameter int unsigned CPU_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [CPU_AW-1:0] offset_i,
  input logic [7:0]        wdata_i,
  input logic              vblank_set_i,
  input logic [14:0]       tmp_addr_o,
  input logic [2:0]        fine_x_o,
  input logic [14:0]       vaddr_o,
  input logic              write_phase_o,
  input logic [7:0]        open_bus_q,
  input logic              vblank
);
  logic [2:0] ofs;
  assign ofs = offset_i[2:0];

  p_vaddr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && ofs == 3'd6 && write_phase_o) |=> $stable(vaddr_o));

  p_vaddr_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == 3'd6 && write_phase_o) |=> vaddr_o == tmp_addr_o);

  p_bit14_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ofs == 3'd6 && !write_phase_o) |=> !tmp_addr_o[14]);

  p_fine_x_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && ofs == 3'd5 && !write_phase_o) |=> $stable(fine_x_o));

  p_phase_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && ofs == 3'd2) |=> !write_phase_o);

  p_vblank_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_set_i |=> vblank);

  p_open_bus_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> open_bus_q == $past(wdata_i));
endmodule

bind vdc_reg_front vdc_reg_front_chk #(.CPU_AW(CPU_AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .offset_i      (offset_i),
  .wdata_i       (wdata_i),
  .vblank_set_i  (vblank_set_i),
  .tmp_addr_o    (tmp_addr_o),
  .fine_x_o      (fine_x_o),
  .vaddr_o       (vaddr_o),
  .write_phase_o (write_phase_o),
  .open_bus_q    (open_bus_q),
  .vblank        (vblank)
);

// File: tb/vdc_reg_front_tb.sv
module vdc_reg_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, vbs = 1'b0;
  logic [7:0]  ofs = '0, wd = '0;
  logic [7:0]  rdata, ctrl, mask, oama;
  logic [14:0] tmp, vaddr;
  logic [2:0]  fx;
  logic        phase;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  vdc_reg_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .rd_en_i(rd), .offset_i(ofs),
    .wdata_i(wd), .vblank_set_i(vbs), .rdata_o(rdata), .ctrl_o(ctrl),
    .mask_o(mask), .oam_addr_o(oama), .tmp_addr_o(tmp), .fine_x_o(fx),
    .vaddr_o(vaddr), .write_phase_o(phase)
  );

  // {offset, data, exp tmp, exp fine x, exp vaddr, exp phase, tag}
  typedef struct packed {
    logic [7:0]  o;
    logic [7:0]  d;
    logic [14:0] t;
    logic [2:0]  f;
    logic [14:0] v;
    logic        p;
    logic [31:0] tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h03, 15'h0C00, 3'd0, 15'h0000, 1'b0, "R3"},
    '{8'h05, 8'h7D, 15'h0C0F, 3'd5, 15'h0000, 1'b1, "R5"},
    '{8'h05, 8'h5E, 15'h6D6F, 3'd5, 15'h0000, 1'b0, "R6"},
    '{8'h06, 8'hFF, 15'h3F6F, 3'd5, 15'h0000, 1'b1, "R7"},
    '{8'h06, 8'h12, 15'h3F12, 3'd5, 15'h3F12, 1'b0, "R8"},
    '{8'h0D, 8'h00, 15'h3F00, 3'd0, 15'h3F12, 1'b1, "R2"},
    '{8'h16, 8'h21, 15'h3F21, 3'd0, 15'h3F21, 1'b0, "R9"},
    '{8'h00, 8'h00, 15'h3321, 3'd0, 15'h3F21, 1'b0, "R3"},
    '{8'h06, 8'h40, 15'h0021, 3'd0, 15'h3F21, 1'b1, "R7"},
    '{8'h05, 8'hFF, 15'h73E1, 3'd0, 15'h3F21, 1'b0, "R9"},
    '{8'h02, 8'hA5, 15'h73E1, 3'd0, 15'h3F21, 1'b0, "R12"}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] o, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; ofs = o; wd = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // returns combinational read data, side effects at the following edge
  task automatic do_rd(input logic [7:0] o, input logic vb, output logic [7:0] r);
    @(negedge clk); rd = 1'b1; ofs = o; vbs = vb;
    #1 r = rdata;
    @(negedge clk); rd = 1'b0; vbs = 1'b0;
  endtask

  task automatic pulse_vb();
    @(negedge clk); vbs = 1'b1;
    @(negedge clk); vbs = 1'b0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {ctrl, mask, oama, tmp, fx, vaddr, phase}, '0);
    ofs = 8'h02; #1 chk("R1", rdata, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i].o, VEC[i].d);
      chk($sformatf("%s vec%0d", VEC[i].tag, i), {tmp, fx, vaddr, phase},
          {VEC[i].t, VEC[i].f, VEC[i].v, VEC[i].p});
    end

    // R12 write to status slot touched nothing else; latch holds A5
    chk("R12", ctrl, 8'h00);
    do_rd(8'h07, 1'b0, r); chk("R12 R13", r, 8'hA5);

    // R4
    do_wr(8'h01, 8'h1E); chk("R4", mask, 8'h1E);
    do_wr(8'h03, 8'h80); chk("R4", oama, 8'h80);
    do_wr(8'h07, 8'h33); chk("R12", {ctrl, mask, oama, tmp}, {8'h00, 8'h1E, 8'h80, 15'h73E1});

    // R10 status read content and flag clear
    pulse_vb();
    do_rd(8'h02, 1'b0, r); chk("R10", r, 8'h93);
    do_rd(8'h02, 1'b0, r); chk("R10", r, 8'h13);

    // R10 status read between two halves resets phase
    do_wr(8'h05, 8'h0A); chk("R10", {phase, fx}, {1'b1, 3'd2});
    do_rd(8'h0A, 1'b0, r); chk("R10", phase, 1'b0);
    do_wr(8'h05, 8'h07); chk("R10 R5", {phase, fx, tmp[4:0]}, {1'b1, 3'd7, 5'd0});

    // R13 non-status reads leave phase and flag alone
    pulse_vb();
    do_rd(8'h00, 1'b0, r); chk("R13", r, 8'h07);
    do_rd(8'h04, 1'b0, r); chk("R13", phase, 1'b1);
    do_rd(8'h02, 1'b0, r); chk("R13", r, 8'h87);

    // R11 set wins over coincident clear
    do_rd(8'h02, 1'b1, r); chk("R11", r, 8'h07);
    do_rd(8'h02, 1'b0, r); chk("R11", r, 8'h87);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule